// File: doc/BRIEF.md
# Test Pattern Source and Checker

This block feeds a bus transfer engine with 8-bit payload bytes drawn from one of three deterministic sequences, and checks bytes coming back from the far end against the same sequence. The sequences are a plain binary count, a Fibonacci series, and a reflected binary (Gray) count. A two-bit select chooses the sequence. The source and the checker each keep their own position in it.

On the transmit side a consumer pulses a request. The block then presents the next byte, with a valid flag, one cycle later. On the receive side every byte handed in with a strobe is compared with the value the checker expects at that position. The first difference sets a flag that stays set. A restart strobe, or any change of the sequence select, puts both sides back at the first value of the sequence and clears the flag.

Top module: `pat_src_chk`

## Requirements
- R1: After reset `byte_vld` and `mismatch` are low, and the first byte issued and the first byte expected are 0x00 in every sequence.
- R2: A request in a cycle with no restart makes `byte_vld` high in the next cycle, with `byte_out` carrying the issued byte. In every other cycle `byte_vld` is low.
- R3: With select value 0 (and also with value 3) successive bytes count up by one from 0x00, and 0xFF is followed by 0x00.
- R4: With select value 1 the bytes follow 0, 1, 1, 2, 3, 5, 8, 13, ... where each term is the sum of the two before it. After 233, whose successor would not fit in 8 bits, the series starts again at 0, 1.
- R5: With select value 2 the n-th byte (counting from 0, modulo 256) is n XOR (n >> 1). Every byte differs from the one before it in exactly one bit, including across the wrap from 0x80 back to 0x00.
- R6: A restart strobe returns both source and checker to the first value of the sequence and clears `mismatch`. A request or receive strobe in the same cycle is dropped.
- R7: A cycle in which the select differs from its value in the previous cycle acts as a restart for both sides.
- R8: The checker advances only on cycles with `rx_vld` high. It compares `rx_byte` with its expected value, and `rx_byte` is ignored while `rx_vld` is low.
- R9: The first compared byte that differs sets `mismatch` one cycle later. It stays set, whatever is received afterwards, until reset or a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Sequence select: 0 count, 1 Fibonacci, 2 Gray, 3 count |
| restart | input | 1 | Return both sides to the first value |
| next_req | input | 1 | Request the next source byte |
| byte_out | output | 8 | Issued byte |
| byte_vld | output | 1 | High for one cycle per issued byte |
| rx_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| mismatch | output | 1 | Sticky compare failure flag |

## Verification
The assertions check the local rules of each step on every cycle. These are the plus-one step of the count, the single-bit change of the Gray step, the non-decreasing Fibonacci step that may only fall back to zero, a return to zero after any clear, the one-cycle request-to-valid timing, and the set, hold and clear of the mismatch flag. Only the bench's scenarios can show the exact values: the full Fibonacci period and its wrap after 233, the count and Gray wraps at 256, the request dropped in a restart cycle, and the checker keeping its position across idle cycles and ignoring data while no strobe is present.

// File: rtl/pat_pkg.sv
package pat_pkg;

    localparam int PAT_W = 8;

    typedef enum logic [1:0] {
        PM_INC     = 2'd0,
        PM_FIB     = 2'd1,
        PM_GRAY    = 2'd2,
        PM_INC_ALT = 2'd3
    } pat_mode_e;

    // Fibonacci upper term carries one spare bit to detect the overflow.
    typedef struct packed {
        logic [PAT_W-1:0] cnt;
        logic [PAT_W-1:0] fa;
        logic [PAT_W:0]   fb;
    } seq_state_t;

    function automatic seq_state_t seq_first();
        seq_state_t s;
        s.cnt = '0;
        s.fa  = '0;
        s.fb  = {{PAT_W{1'b0}}, 1'b1};
        return s;
    endfunction

    function automatic seq_state_t seq_step(pat_mode_e m, seq_state_t s);
        seq_state_t n;
        n = s;
        case (m)
            PM_FIB: begin
                if (s.fb[PAT_W]) begin
                    n = seq_first();
                end else begin
                    n.fa = s.fb[PAT_W-1:0];
                    n.fb = {1'b0, s.fa} + s.fb;
                end
            end
            default: n.cnt = s.cnt + 1'b1;
        endcase
        return n;
    endfunction

    function automatic logic [PAT_W-1:0] seq_value(pat_mode_e m, seq_state_t s);
        case (m)
            PM_FIB:  return s.fa;
            PM_GRAY: return s.cnt ^ (s.cnt >> 1);
            default: return s.cnt;
        endcase
    endfunction

endpackage

// File: rtl/pat_ctl.sv
module pat_ctl
    import pat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       restart,
    output pat_mode_e  mode_q,
    output logic       clr
);

    always_ff @(posedge clk) begin
        mode_q <= pat_mode_e'(mode);
    end

    assign clr = restart | (pat_mode_e'(mode) != mode_q);

    a_r7_change_clears: assert property (@(posedge clk) disable iff (rst)
        (!restart && $past(mode) != mode && !$past(rst)) |-> clr);

endmodule

// File: rtl/pat_engine.sv
module pat_engine
    import pat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  pat_mode_e        mode,
    output logic [PAT_W-1:0] value
);

    seq_state_t st;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st <= seq_first();
        end else if (step) begin
            st <= seq_step(mode, st);
        end
    end

    assign value = seq_value(mode, st);

    // R6: any clear lands on the first value of the sequence
    a_r6_clear_to_first: assert property (@(posedge clk) disable iff (rst)
        clr |=> value == '0);

    a_r3_inc_step: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && (mode == PM_INC || mode == PM_INC_ALT))
        |=> value == $past(value) + 1'b1);

    a_r5_gray_one_bit: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && mode == PM_GRAY)
        |=> $countones(value ^ $past(value)) == 1);

    a_r4_fib_grows_or_wraps: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && mode == PM_FIB)
        |=> (value >= $past(value)) || (value == '0));

endmodule

// File: rtl/pat_gen.sv
module pat_gen
    import pat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  pat_mode_e        mode,
    input  logic             next_req,
    output logic [PAT_W-1:0] byte_out,
    output logic             byte_vld
);

    logic             take;
    logic [PAT_W-1:0] cur;

    assign take = next_req & ~clr;

    pat_engine u_eng (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .step  (take),
        .mode  (mode),
        .value (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_out <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= take;
            if (take) begin
                byte_out <= cur;
            end
        end
    end

    a_r2_req_gives_valid: assert property (@(posedge clk) disable iff (rst)
        (next_req && !clr) |=> byte_vld);

    a_r2_no_req_no_valid: assert property (@(posedge clk) disable iff (rst)
        !(next_req && !clr) |=> !byte_vld);

endmodule

// File: rtl/pat_chk.sv
module pat_chk
    import pat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  pat_mode_e        mode,
    input  logic             rx_vld,
    input  logic [PAT_W-1:0] rx_byte,
    output logic             mismatch
);

    logic             take;
    logic [PAT_W-1:0] expv;

    assign take = rx_vld & ~clr;

    pat_engine u_eng (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .step  (take),
        .mode  (mode),
        .value (expv)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mismatch <= 1'b0;
        end else if (take && rx_byte != expv) begin
            mismatch <= 1'b1;
        end
    end

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (mismatch && !clr) |=> mismatch);

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> !mismatch);

    a_r8_diff_flags: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && !clr && rx_byte != expv) |=> mismatch);

endmodule

// File: rtl/pat_src_chk.sv
module pat_src_chk
    import pat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             restart,
    input  logic             next_req,
    output logic [PAT_W-1:0] byte_out,
    output logic             byte_vld,
    input  logic             rx_vld,
    input  logic [PAT_W-1:0] rx_byte,
    output logic             mismatch
);

    pat_mode_e mode_q;
    logic      clr;

    pat_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .restart (restart),
        .mode_q  (mode_q),
        .clr     (clr)
    );

    pat_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .mode     (mode_q),
        .next_req (next_req),
        .byte_out (byte_out),
        .byte_vld (byte_vld)
    );

    pat_chk u_chk (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .mode     (mode_q),
        .rx_vld   (rx_vld),
        .rx_byte  (rx_byte),
        .mismatch (mismatch)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!byte_vld && !mismatch));

endmodule

// File: tb/tb_pat_src_chk.sv
module tb_pat_src_chk;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic       restart;
    logic       next_req;
    logic [7:0] byte_out;
    logic       byte_vld;
    logic       rx_vld;
    logic [7:0] rx_byte;
    logic       mismatch;

    always #2.5 clk = ~clk;

    pat_src_chk dut (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .restart  (restart),
        .next_req (next_req),
        .byte_out (byte_out),
        .byte_vld (byte_vld),
        .rx_vld   (rx_vld),
        .rx_byte  (rx_byte),
        .mismatch (mismatch)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string tag   = "R1";

    // reference model state
    int         gen_n, chk_n;
    logic [1:0] mode_prev;
    bit         e_vld, e_mis;
    logic [7:0] e_byte;
    bit         have_prev;
    logic [7:0] prev_byte;

    function automatic logic [7:0] ref_val(input logic [1:0] m, input int n);
        int a, b, t, k;
        if (m == 2'd1) begin
            a = 0; b = 1; k = n % 14;
            for (int i = 0; i < k; i++) begin
                t = a + b; a = b; b = t;
            end
            return a[7:0];
        end else if (m == 2'd2) begin
            k = n % 256;
            return 8'(k ^ (k >> 1));
        end
        return 8'(n % 256);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycle();
        bit clr;
        @(posedge clk);
        if (rst) begin
            mode_prev = mode; gen_n = 0; chk_n = 0;
            e_vld = 0; e_mis = 0; e_byte = 8'h00; have_prev = 0;
        end else begin
            clr = restart || (mode != mode_prev);
            mode_prev = mode;
            if (clr) begin
                gen_n = 0; chk_n = 0; e_vld = 0; e_mis = 0; have_prev = 0;
            end else begin
                e_vld = next_req;
                if (next_req) begin
                    e_byte = ref_val(mode, gen_n);
                    gen_n++;
                end
                if (rx_vld) begin
                    if (rx_byte != ref_val(mode, chk_n)) e_mis = 1;
                    chk_n++;
                end
            end
        end
        @(negedge clk);
        check(tag, byte_vld, e_vld);
        if (e_vld) begin
            check(tag, byte_out, e_byte);
            if (mode == 2'd2 && have_prev)   // R5 single-bit step
                check("R5", $countones(byte_out ^ prev_byte), 1);
            prev_byte = byte_out;
            have_prev = 1;
        end
        check(tag, mismatch, e_mis);
    endtask

    task automatic idle_in();
        restart = 0; next_req = 0; rx_vld = 0; rx_byte = 8'hA5;
    endtask

    task automatic do_reset(input logic [1:0] m);
        idle_in();
        mode = m; rst = 1;
        cycle(); cycle();
        rst = 0;
    endtask

    task automatic run_reqs(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            next_req = gaps ? (i % 3 != 2) : 1'b1;
            cycle();
        end
        next_req = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state and first byte
        tag = "R1";
        do_reset(2'd0);
        cycle();
        next_req = 1; cycle(); next_req = 0;
        check("R1", byte_out, 8'h00);

        // R2 request timing with gaps, R3 count through the wrap
        tag = "R2";
        run_reqs(20, 1'b1);
        tag = "R3";
        run_reqs(260, 1'b0);

        // R7 select change acts as restart, R4 Fibonacci over two periods
        tag = "R7";
        mode = 2'd1; next_req = 1; cycle();
        tag = "R4";
        run_reqs(30, 1'b0);

        // R5 Gray through the wrap
        tag = "R7";
        mode = 2'd2; cycle();
        tag = "R5";
        run_reqs(262, 1'b0);

        // R6 restart mid-stream with a request in the same cycle
        tag = "R6";
        mode = 2'd0; cycle();
        run_reqs(5, 1'b0);
        restart = 1; next_req = 1; cycle();
        restart = 0; next_req = 1; cycle(); next_req = 0;
        check("R6", byte_out, 8'h00);

        // R3 select value 3 counts like value 0
        tag = "R3";
        mode = 2'd3; cycle();
        run_reqs(10, 1'b0);

        // R8 checker follows correct data with idle gaps and junk data
        tag = "R8";
        mode = 2'd1; cycle();
        for (int i = 0; i < 40; i++) begin
            rx_vld  = (i % 4 != 3);
            rx_byte = rx_vld ? ref_val(mode, chk_n) : 8'hEE;
            cycle();
        end
        rx_vld = 0;
        check("R8", mismatch, 0);

        // R9 wrong byte sets the flag; it then holds over correct bytes
        tag = "R9";
        rx_vld = 1; rx_byte = ref_val(mode, chk_n) ^ 8'h01; cycle();
        check("R9", mismatch, 1);
        for (int i = 0; i < 8; i++) begin
            rx_byte = ref_val(mode, chk_n); cycle();
        end
        rx_vld = 0;
        check("R9", mismatch, 1);

        // R6 restart clears the flag; receive strobe in that cycle dropped
        tag = "R6";
        restart = 1; rx_vld = 1; rx_byte = 8'h77; cycle();
        restart = 0; rx_vld = 0;
        check("R6", mismatch, 0);
        mode = 2'd2; cycle();
        tag = "R8";
        for (int i = 0; i < 12; i++) begin
            rx_vld = 1; rx_byte = ref_val(mode, chk_n); next_req = 1; cycle();
        end
        idle_in();
        cycle();

        // R1 reset captures a non-count select
        tag = "R1";
        do_reset(2'd1);
        run_reqs(4, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule